// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small bank of 8-bit system configuration registers on a simple synchronous peripheral bus. The bus has an address, write data, a write strobe, a read strobe and a registered read-data return. The bank holds the access-wait setting for peripheral port A, the configuration of the USB port (interrupt enable, snooze control and access wait), an internal-RAM wait byte, a boot configuration byte, a RAM placement byte, and a protect register that holds an unlock key.

Five of the registers are guarded. A bus write changes a guarded field only while the protect register holds the value 0x96. The snooze control bit shares a register with guarded fields but is never guarded, so one write to that register can update the snooze bit while the guarded fields next to it stay unchanged. A write that reaches a guarded offset while the bank is locked raises a one-cycle violation pulse, which debug logic can watch. Every stored field also drives an output port, so the logic that inserts wait states and routes interrupts can use it directly.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the registers hold these values: peripheral-A wait = 7, USB register = 0x07 (interrupt enable 0, snooze 0, wait 7), RAM wait = 0x00, boot = 0x00, RAM location = 0x00, protect = 0x00.
- R2: A write to a guarded field changes it only when the protect register holds 0x96 at the write. Otherwise the field keeps its value. The guarded fields are: offset 0x10 bits 2:0; offset 0x12 bit 6 and bits 2:0; offsets 0x14, 0x16 and 0x18 (all 8 bits).
- R3: The protect register at offset 0x20 accepts every write, whatever its current value, and reads back the stored byte.
- R4: The snooze bit (offset 0x12, bit 5) takes the written value on every write to 0x12, whether the bank is locked or unlocked.
- R5: A write of 0 to the peripheral-A wait field (offset 0x10, bits 2:0) is discarded and the field keeps its value. This field never holds 0.
- R6: Reserved bits read as 0: bits 7:3 of offset 0x10, and bits 7, 4 and 3 of offset 0x12.
- R7: A read from any offset other than 0x10, 0x12, 0x14, 0x16, 0x18 or 0x20 returns 0x00. A write to such an offset changes no register.
- R8: prot_viol is high for exactly the cycle after a clock edge at which a write reached a guarded offset (0x10 to 0x18 above) while the protect register did not hold 0x96. It is low at all other times.
- R9: bus_rdata is updated one cycle after a read strobe, with the register contents from before that edge. It holds its value when no read is strobed.
- R10: The configuration outputs always equal the stored field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| waita_cyc | output | 3 | Peripheral-A access wait count |
| usb_irq_en | output | 1 | USB interrupt enable |
| usb_snooze | output | 1 | USB snooze control |
| usb_wait_cyc | output | 3 | USB access wait count |
| ram_wait_cfg | output | 8 | Internal RAM wait configuration |
| boot_cfg | output | 8 | Boot configuration byte |
| ram_loc_cfg | output | 8 | RAM placement select |
| prot_viol | output | 1 | One-cycle pulse on a blocked guarded write |

## Verification
The assertions assume that bus_addr, bus_wdata, bus_wr and bus_rd are stable and known at every rising edge. They also assume that a write strobe lasts one cycle per intended write. The checker keeps its own copy of the protect key, built from the bus writes it observes, so it assumes that nothing other than the bus changes the key. The bench drives every input on the falling edge and pulses each strobe for exactly one cycle. It picks offsets from the mapped set plus a few unmapped ones, and writes the unlock key often enough that both locked and unlocked windows get long random runs.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int unsigned REG_W = 8;
    localparam int unsigned WAIT_W = 3;

    localparam logic [7:0] OFS_WAITA = 8'h10;
    localparam logic [7:0] OFS_USB   = 8'h12;
    localparam logic [7:0] OFS_RAMW  = 8'h14;
    localparam logic [7:0] OFS_BOOT  = 8'h16;
    localparam logic [7:0] OFS_LOC   = 8'h18;
    localparam logic [7:0] OFS_KEY   = 8'h20;

    localparam logic [7:0] UNLOCK_KEY = 8'h96;

    localparam int unsigned USB_IRQ_BIT = 6;
    localparam int unsigned USB_SNZ_BIT = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_WAITA,
        SEL_USB,
        SEL_RAMW,
        SEL_BOOT,
        SEL_LOC,
        SEL_KEY
    } sel_e;

    typedef struct packed {
        logic             waita;
        logic             usb_guarded;
        logic             usb_snz;
        logic             ramw;
        logic             boot;
        logic             loc;
        logic             key;
    } wen_t;

    typedef struct packed {
        logic [WAIT_W-1:0] waita;
        logic              usb_irq;
        logic              usb_snz;
        logic [WAIT_W-1:0] usb_wait;
        logic [REG_W-1:0]  ramw;
        logic [REG_W-1:0]  boot;
        logic [REG_W-1:0]  loc;
        logic [REG_W-1:0]  key;
        logic              viol;
        logic [REG_W-1:0]  rdata;
    } bank_t;

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
    import cfgbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic              guarded
);

    always_comb begin
        sel = SEL_NONE;
        if      (addr == ADDR_W'(OFS_WAITA)) sel = SEL_WAITA;
        else if (addr == ADDR_W'(OFS_USB))   sel = SEL_USB;
        else if (addr == ADDR_W'(OFS_RAMW))  sel = SEL_RAMW;
        else if (addr == ADDR_W'(OFS_BOOT))  sel = SEL_BOOT;
        else if (addr == ADDR_W'(OFS_LOC))   sel = SEL_LOC;
        else if (addr == ADDR_W'(OFS_KEY))   sel = SEL_KEY;
    end

    always_comb begin
        unique case (sel)
            SEL_WAITA, SEL_USB, SEL_RAMW, SEL_BOOT, SEL_LOC: guarded = 1'b1;
            default:                                         guarded = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfgbank_wgate.sv
module cfgbank_wgate
    import cfgbank_pkg::*;
#(
    parameter int unsigned KEY_W = 8
) (
    input  logic             wr,
    input  sel_e             sel,
    input  logic             guarded,
    input  logic [KEY_W-1:0] key,
    input  logic [REG_W-1:0] wdata,
    output wen_t             wen,
    output logic             viol
);

    logic unlocked;
    logic waita_legal;

    always_comb begin
        unlocked    = (key == KEY_W'(UNLOCK_KEY));
        waita_legal = (wdata[WAIT_W-1:0] != '0);

        wen             = '0;
        wen.waita       = wr && unlocked && (sel == SEL_WAITA) && waita_legal;
        wen.usb_guarded = wr && unlocked && (sel == SEL_USB);
        wen.usb_snz     = wr && (sel == SEL_USB);
        wen.ramw        = wr && unlocked && (sel == SEL_RAMW);
        wen.boot        = wr && unlocked && (sel == SEL_BOOT);
        wen.loc         = wr && unlocked && (sel == SEL_LOC);
        wen.key         = wr && (sel == SEL_KEY);

        viol = wr && guarded && !unlocked;
    end

endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
    import cfgbank_pkg::*;
(
    input  sel_e              sel,
    input  logic [WAIT_W-1:0] waita,
    input  logic              usb_irq,
    input  logic              usb_snz,
    input  logic [WAIT_W-1:0] usb_wait,
    input  logic [REG_W-1:0]  ramw,
    input  logic [REG_W-1:0]  boot,
    input  logic [REG_W-1:0]  loc,
    input  logic [REG_W-1:0]  key,
    output logic [REG_W-1:0]  word
);

    logic [REG_W-1:0] usb_word;

    always_comb begin
        usb_word              = '0;
        usb_word[WAIT_W-1:0]  = usb_wait;
        usb_word[USB_SNZ_BIT] = usb_snz;
        usb_word[USB_IRQ_BIT] = usb_irq;

        unique case (sel)
            SEL_WAITA: word = REG_W'(waita);
            SEL_USB:   word = usb_word;
            SEL_RAMW:  word = ramw;
            SEL_BOOT:  word = boot;
            SEL_LOC:   word = loc;
            SEL_KEY:   word = key;
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [WAIT_W-1:0] WAITA_RST = 3'd7,
    parameter logic [WAIT_W-1:0] USBW_RST  = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [WAIT_W-1:0] waita_cyc,
    output logic              usb_irq_en,
    output logic              usb_snooze,
    output logic [WAIT_W-1:0] usb_wait_cyc,
    output logic [REG_W-1:0]  ram_wait_cfg,
    output logic [REG_W-1:0]  boot_cfg,
    output logic [REG_W-1:0]  ram_loc_cfg,
    output logic              prot_viol
);

    localparam bank_t BANK_RST = '{
        waita:    WAITA_RST,
        usb_irq:  1'b0,
        usb_snz:  1'b0,
        usb_wait: USBW_RST,
        ramw:     '0,
        boot:     '0,
        loc:      '0,
        key:      '0,
        viol:     1'b0,
        rdata:    '0
    };

    bank_t            bank_d, bank_q;
    sel_e             sel;
    logic             guarded;
    wen_t             wen;
    logic             viol;
    logic [REG_W-1:0] rd_word;

    cfgbank_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr    (bus_addr),
        .sel     (sel),
        .guarded (guarded)
    );

    cfgbank_wgate #(.KEY_W(REG_W)) wgate_i (
        .wr      (bus_wr),
        .sel     (sel),
        .guarded (guarded),
        .key     (bank_q.key),
        .wdata   (bus_wdata),
        .wen     (wen),
        .viol    (viol)
    );

    cfgbank_rdmux rdmux_i (
        .sel      (sel),
        .waita    (bank_q.waita),
        .usb_irq  (bank_q.usb_irq),
        .usb_snz  (bank_q.usb_snz),
        .usb_wait (bank_q.usb_wait),
        .ramw     (bank_q.ramw),
        .boot     (bank_q.boot),
        .loc      (bank_q.loc),
        .key      (bank_q.key),
        .word     (rd_word)
    );

    always_comb begin
        bank_d = bank_q;
        if (wen.waita)       bank_d.waita    = bus_wdata[WAIT_W-1:0];
        if (wen.usb_guarded) begin
            bank_d.usb_irq  = bus_wdata[USB_IRQ_BIT];
            bank_d.usb_wait = bus_wdata[WAIT_W-1:0];
        end
        if (wen.usb_snz)     bank_d.usb_snz  = bus_wdata[USB_SNZ_BIT];
        if (wen.ramw)        bank_d.ramw     = bus_wdata;
        if (wen.boot)        bank_d.boot     = bus_wdata;
        if (wen.loc)         bank_d.loc      = bus_wdata;
        if (wen.key)         bank_d.key      = bus_wdata;
        bank_d.viol = viol;
        if (bus_rd)          bank_d.rdata    = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= BANK_RST;
        else        bank_q <= bank_d;
    end

    assign bus_rdata    = bank_q.rdata;
    assign waita_cyc    = bank_q.waita;
    assign usb_irq_en   = bank_q.usb_irq;
    assign usb_snooze   = bank_q.usb_snz;
    assign usb_wait_cyc = bank_q.usb_wait;
    assign ram_wait_cfg = bank_q.ramw;
    assign boot_cfg     = bank_q.boot;
    assign ram_loc_cfg  = bank_q.loc;
    assign prot_viol    = bank_q.viol;

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [WAIT_W-1:0] waita_cyc,
    input logic              usb_irq_en,
    input logic              usb_snooze,
    input logic [WAIT_W-1:0] usb_wait_cyc,
    input logic [REG_W-1:0]  ram_wait_cfg,
    input logic [REG_W-1:0]  boot_cfg,
    input logic [REG_W-1:0]  ram_loc_cfg,
    input logic              prot_viol
);

    logic [REG_W-1:0] shadow_key;
    logic             locked;
    logic             hit_guard;
    logic             hit_none;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      shadow_key <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(OFS_KEY)) shadow_key <= bus_wdata;
    end

    assign locked    = (shadow_key != UNLOCK_KEY);
    assign hit_guard = (bus_addr == ADDR_W'(OFS_WAITA)) || (bus_addr == ADDR_W'(OFS_USB)) ||
                       (bus_addr == ADDR_W'(OFS_RAMW))  || (bus_addr == ADDR_W'(OFS_BOOT)) ||
                       (bus_addr == ADDR_W'(OFS_LOC));
    assign hit_none  = !hit_guard && (bus_addr != ADDR_W'(OFS_KEY));

    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(waita_cyc) && $stable(usb_irq_en) && $stable(usb_wait_cyc) &&
                   $stable(ram_wait_cfg) && $stable(boot_cfg) && $stable(ram_loc_cfg));

    p_snooze_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_USB)) |=> usb_snooze == $past(bus_wdata[USB_SNZ_BIT]));

    p_waita_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        waita_cyc != '0);

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_WAITA)) |=> bus_rdata[7:3] == '0);

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_none) |=> bus_rdata == '0);

    p_viol_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_guard && locked) |=> prot_viol);

    p_viol_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit_guard && locked) |=> !prot_viol);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind cfgbank_top cfgbank_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .waita_cyc    (waita_cyc),
    .usb_irq_en   (usb_irq_en),
    .usb_snooze   (usb_snooze),
    .usb_wait_cyc (usb_wait_cyc),
    .ram_wait_cfg (ram_wait_cfg),
    .boot_cfg     (boot_cfg),
    .ram_loc_cfg  (ram_loc_cfg),
    .prot_viol    (prot_viol)
);

// File: tb/cfgbank_top_tb_top.sv
module cfgbank_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] waita_cyc, usb_wait_cyc;
    logic       usb_irq_en, usb_snooze, prot_viol;
    logic [7:0] ram_wait_cfg, boot_cfg, ram_loc_cfg;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [2:0] m_wa, m_uw;
    logic       m_irq, m_snz;
    logic [7:0] m_ramw, m_boot, m_loc, m_key;

    always #4 clk = ~clk;

    cfgbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .waita_cyc(waita_cyc), .usb_irq_en(usb_irq_en), .usb_snooze(usb_snooze),
        .usb_wait_cyc(usb_wait_cyc), .ram_wait_cfg(ram_wait_cfg), .boot_cfg(boot_cfg),
        .ram_loc_cfg(ram_loc_cfg), .prot_viol(prot_viol)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [7:0] a);
        case (a)
            8'h10:   return {5'b0, m_wa};
            8'h12:   return {1'b0, m_irq, m_snz, 2'b0, m_uw};
            8'h14:   return m_ramw;
            8'h16:   return m_boot;
            8'h18:   return m_loc;
            8'h20:   return m_key;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit is_guarded(logic [7:0] a);
        return a == 8'h10 || a == 8'h12 || a == 8'h14 || a == 8'h16 || a == 8'h18;
    endfunction

    task automatic model_reset();
        m_wa = 3'd7; m_uw = 3'd7; m_irq = 0; m_snz = 0;
        m_ramw = 0; m_boot = 0; m_loc = 0; m_key = 0;
    endtask

    task automatic check_outputs(string req);
        check({req, " waita_cyc"}, 32'(waita_cyc), 32'(m_wa));
        check({req, " usb_irq_en"}, 32'(usb_irq_en), 32'(m_irq));
        check({req, " usb_snooze"}, 32'(usb_snooze), 32'(m_snz));
        check({req, " usb_wait_cyc"}, 32'(usb_wait_cyc), 32'(m_uw));
        check({req, " ram_wait_cfg"}, 32'(ram_wait_cfg), 32'(m_ramw));
        check({req, " boot_cfg"}, 32'(boot_cfg), 32'(m_boot));
        check({req, " ram_loc_cfg"}, 32'(ram_loc_cfg), 32'(m_loc));
    endtask

    // write then update the model; R8 pulse sampled one cycle after the strobe edge
    task automatic wr(logic [7:0] a, logic [7:0] d);
        bit unl;
        bit exp_v;
        unl   = (m_key == 8'h96);
        exp_v = is_guarded(a) && !unl;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            8'h10: if (unl && d[2:0] != 0) m_wa = d[2:0];
            8'h12: begin
                m_snz = d[5];
                if (unl) begin m_irq = d[6]; m_uw = d[2:0]; end
            end
            8'h14: if (unl) m_ramw = d;
            8'h16: if (unl) m_boot = d;
            8'h18: if (unl) m_loc = d;
            8'h20: m_key = d;
            default: ;
        endcase
        check("R8 prot_viol", 32'(prot_viol), 32'(exp_v));
        check_outputs("R10");
        @(negedge clk);
        check("R8 pulse width", 32'(prot_viol), 32'h0);
    endtask

    task automatic rd(logic [7:0] a, string req);
        logic [7:0] e;
        e = exp_read(a);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, 32'(bus_rdata), 32'(e));
        @(negedge clk);
        check("R9 rdata hold", 32'(bus_rdata), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] amap [9];
        void'($urandom(32'h00c0ffee));
        amap = '{8'h10, 8'h12, 8'h14, 8'h16, 8'h18, 8'h20, 8'h11, 8'h1e, 8'hff};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: defaults
        check_outputs("R1 reset");
        check("R1 prot_viol", 32'(prot_viol), 32'h0);
        rd(8'h10, "R1 waitA read");
        rd(8'h12, "R1 usb read");
        rd(8'h20, "R1 key read");

        // R2: locked writes blocked
        wr(8'h10, 8'h03); wr(8'h12, 8'h47); wr(8'h14, 8'h5a);
        wr(8'h16, 8'hc3); wr(8'h18, 8'h81);
        rd(8'h14, "R2 locked ramw"); rd(8'h12, "R2 locked usb");
        // R4: snooze writable while locked
        wr(8'h12, 8'h20);
        check("R4 snooze locked", 32'(usb_snooze), 32'h1);
        // R3: key register
        wr(8'h20, 8'h95); rd(8'h20, "R3 key readback");
        wr(8'h10, 8'h02); check("R2 near-key still locked", 32'(waita_cyc), 32'h7);
        wr(8'h20, 8'h96); rd(8'h20, "R3 key unlock");
        // R2: unlocked writes land
        wr(8'h10, 8'hfa); wr(8'h12, 8'hff); wr(8'h14, 8'h5a);
        wr(8'h16, 8'hc3); wr(8'h18, 8'h81);
        check("R2 waitA unlocked", 32'(waita_cyc), 32'h2);
        rd(8'h10, "R6 waitA reserved");
        rd(8'h12, "R6 usb reserved");
        // R5: zero wait ignored
        wr(8'h10, 8'hf8);
        check("R5 zero wait kept", 32'(waita_cyc), 32'h2);
        wr(8'h10, 8'h01);
        check("R5 min wait", 32'(waita_cyc), 32'h1);
        // R7: unmapped
        wr(8'h11, 8'hff); wr(8'h1f, 8'h33);
        rd(8'h11, "R7 unmapped read"); rd(8'hff, "R7 unmapped read hi");
        rd(8'h18, "R7 no side effect");
        // relock
        wr(8'h20, 8'h00);
        wr(8'h18, 8'h00); rd(8'h18, "R2 relocked");

        // random mix
        for (int i = 0; i < 800; i++) begin
            logic [7:0] a, d;
            a = amap[$urandom_range(8, 0)];
            d = 8'($urandom);
            if (a == 8'h20 && $urandom_range(1, 0) == 1) d = 8'h96;
            if ($urandom_range(2, 0) == 0) rd(a, "R6 R7 R9 random read");
            else                           wr(a, d);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule